// File: doc/BRIEF.md
# DMA Channel Interrupt Event Generator

This block sits beside one DMA channel and turns write-completion and request-handshake activity into interrupt status. Each time the channel writes an element to its destination, the block gets the element's starting byte offset within the current frame and its size in bytes. It also gets the frame length in bytes and the number of frames in the block. From these it tracks which frame is being written and flags four positional events: the end of a frame, the middle of a frame, the start of the last frame, and the end of the whole block.

It also counts request arrivals against service completions to catch requests that get dropped. It passes a bus-error strobe through as a sixth event.

Every event sets a sticky status bit, whether or not its enable is set. A status read strobe returns the bits and clears them, and a single interrupt line is raised whenever an enabled bit is set. Software decoding and the data path stay outside. The channel start strobe re-arms the frame and request tracking for a new transfer.

Top module: `dma_irq_gen`

## Requirements
- R1: Status bit 0 (frame end) is set when a write covers byte frameBytes-1 of the frame, that is wrPos <= frameBytes-1 < wrPos+wrBytes.
- R2: Status bit 1 (frame middle) is set when a write covers byte floor(frameBytes/2), counting from zero.
- R3: Status bit 2 (last frame started) is set when a write with wrPos 0 occurs while the frame index equals frameCount-1.
- R4: Status bit 3 (block end) is set when a write covers byte frameBytes-1 while the frame index equals frameCount-1.
- R5: The frame index starts at zero after reset and after chanStart. A write in the chanStart cycle is judged as frame 0. The index advances by one on each frame end that is not in the last frame, and it holds in the last frame.
- R6: Status bit 4 (request dropped) is set when reqArrive occurs without svcDone while two requests are already outstanding (one in service and one waiting). svcDone retires one outstanding request before the same cycle's arrival is counted, and chanStart empties the count.
- R7: Status bit 5 (bus error) is set by busErr.
- R8: An event sets its status bit at the next clock edge whatever intEnable holds. The bit stays set until it is read.
- R9: In a cycle with statusRd high, statusData shows the bits currently held. After the edge, every bit is clear except those set by events in that same cycle.
- R10: irq is high exactly when some status bit and its intEnable bit are both 1, and it follows intEnable with no clock delay.
- R11: During and right after reset, statusData is all zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanStart | input | 1 | Channel start; clears frame and request tracking |
| wrValid | input | 1 | One element written to the destination this cycle |
| wrPos | input | POS_W | Byte offset of the element's first byte within the frame |
| wrBytes | input | SIZE_W | Element size in bytes (at least 1) |
| frameBytes | input | POS_W | Frame length in bytes (at least 1) |
| frameCount | input | FRM_W | Frames in the block (at least 1) |
| reqArrive | input | 1 | A new DMA request arrived |
| svcDone | input | 1 | Service of one request finished |
| busErr | input | 1 | Bus error strobe |
| statusRd | input | 1 | Status read; returns and clears the status bits |
| intEnable | input | 6 | Per-bit interrupt enables |
| statusData | output | 6 | Sticky status bits |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- Each event strobe lands in its status bit.
- Status holds steady when there is no read and no event.
- A read with no new event empties the status.
- Channel start zeroes the frame and request tracking.
- A non-final frame end advances the frame index by exactly one.
- A drop leaves two requests outstanding.

The bench scenarios are needed for the positional decode itself. That covers odd and one-byte frames, middle bytes inside wider elements, last-frame detection across several frames, and restart in the middle of a block. The scenarios also cover the read-versus-event race and the masking of the interrupt line by the enables.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int NUM_EVT = 6;

  localparam int EVT_FRAME_END = 0;
  localparam int EVT_FRAME_MID = 1;
  localparam int EVT_LAST_START = 2;
  localparam int EVT_BLOCK_END = 3;
  localparam int EVT_REQ_DROP = 4;
  localparam int EVT_BUS_ERR = 5;

  typedef struct packed {
    logic frameEnd;
    logic frameMid;
    logic lastStart;
    logic blockEnd;
    logic reqDrop;
    logic busErr;
  } evtStrobe_t;

  function automatic logic [NUM_EVT-1:0] evtToVec(evtStrobe_t e);
    logic [NUM_EVT-1:0] v;
    v = '0;
    v[EVT_FRAME_END] = e.frameEnd;
    v[EVT_FRAME_MID] = e.frameMid;
    v[EVT_LAST_START] = e.lastStart;
    v[EVT_BLOCK_END] = e.blockEnd;
    v[EVT_REQ_DROP] = e.reqDrop;
    v[EVT_BUS_ERR] = e.busErr;
    return v;
  endfunction

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int SIZE_W = 3,
  parameter int FRM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanStart,
  input  logic              wrValid,
  input  logic [POS_W-1:0]  wrPos,
  input  logic [SIZE_W-1:0] wrBytes,
  input  logic [POS_W-1:0]  frameBytes,
  input  logic [FRM_W-1:0]  frameCount,
  input  logic              reqArrive,
  input  logic              svcDone,
  input  logic              busErr,
  output evtStrobe_t        evt
);

  localparam int SUM_W = POS_W + 1;
  localparam logic [1:0] REQ_FULL = 2'd2;

  logic [FRM_W-1:0] frameIdx, frameBase, frameNext, lastIdx;
  logic [1:0]       reqCnt, reqBase, reqAfterDone, reqNext;
  logic [SUM_W-1:0] posExt, endExcl, midPos, lastPos;
  logic             coversLast, coversMid, onLast, dropNow;

  // Position decode for the element written this cycle
  always_comb begin
    frameBase = chanStart ? '0 : frameIdx;
    lastIdx = frameCount - FRM_W'(1);
    onLast = (frameBase == lastIdx);
    posExt = SUM_W'(wrPos);
    endExcl = posExt + SUM_W'(wrBytes);
    midPos = SUM_W'(frameBytes >> 1);
    lastPos = SUM_W'(frameBytes) - SUM_W'(1);
    coversLast = wrValid && (posExt <= lastPos) && (endExcl > lastPos);
    coversMid = wrValid && (posExt <= midPos) && (endExcl > midPos);
    frameNext = (coversLast && !onLast) ? frameBase + FRM_W'(1) : frameBase;
  end

  // Outstanding request tracking: done retires first, then arrival counts
  always_comb begin
    reqBase = chanStart ? 2'd0 : reqCnt;
    reqAfterDone = (svcDone && reqBase != 2'd0) ? reqBase - 2'd1 : reqBase;
    dropNow = reqArrive && (reqAfterDone == REQ_FULL);
    if (reqArrive && reqAfterDone != REQ_FULL) reqNext = reqAfterDone + 2'd1;
    else reqNext = reqAfterDone;
  end

  always_comb begin
    evt.frameEnd = coversLast;
    evt.frameMid = coversMid;
    evt.lastStart = wrValid && (wrPos == '0) && onLast;
    evt.blockEnd = coversLast && onLast;
    evt.reqDrop = dropNow;
    evt.busErr = busErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameIdx <= '0;
      reqCnt <= '0;
    end else begin
      frameIdx <= frameNext;
      reqCnt <= reqNext;
    end
  end

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    chanStart && !wrValid && !reqArrive |=> frameIdx == '0 && reqCnt == 2'd0);

  assert_frame_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    evt.frameEnd && !evt.blockEnd && !chanStart |=> frameIdx == $past(frameIdx) + FRM_W'(1));

  assert_drop_keeps_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    evt.reqDrop |=> reqCnt == REQ_FULL);

  assert_req_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqCnt <= REQ_FULL);

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  evtStrobe_t         evt,
  input  logic               statusRd,
  input  logic [NUM_EVT-1:0] intEnable,
  output logic [NUM_EVT-1:0] statusData,
  output logic               irq
);

  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_EVT-1:0] statusQ;

  assign evtVec = evtToVec(evt);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else statusQ[i] <= (statusQ[i] && !statusRd) || evtVec[i];
    end

    assert_evt_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> statusQ[i]);
  end

  assign statusData = statusQ;
  assign irq = |(statusQ & intEnable);

  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd && evtVec == '0 |=> $stable(statusQ));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && evtVec == '0 |=> statusQ == '0);

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
  import dma_irq_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int SIZE_W = 3,
  parameter int FRM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanStart,
  input  logic              wrValid,
  input  logic [POS_W-1:0]  wrPos,
  input  logic [SIZE_W-1:0] wrBytes,
  input  logic [POS_W-1:0]  frameBytes,
  input  logic [FRM_W-1:0]  frameCount,
  input  logic              reqArrive,
  input  logic              svcDone,
  input  logic              busErr,
  input  logic              statusRd,
  input  logic [5:0]        intEnable,
  output logic [5:0]        statusData,
  output logic              irq
);

  evtStrobe_t evt;

  dma_irq_ctrl #(.POS_W(POS_W), .SIZE_W(SIZE_W), .FRM_W(FRM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanStart(chanStart), .wrValid(wrValid),
    .wrPos(wrPos), .wrBytes(wrBytes), .frameBytes(frameBytes),
    .frameCount(frameCount), .reqArrive(reqArrive), .svcDone(svcDone),
    .busErr(busErr), .evt(evt)
  );

  dma_irq_status u_status (
    .clk(clk), .rstN(rstN), .evt(evt), .statusRd(statusRd),
    .intEnable(intEnable), .statusData(statusData), .irq(irq)
  );

  always_comb begin
    assert_irq_low_when_masked_R10: assert (!(rstN && intEnable == '0 && irq));
  end

endmodule

// File: tb/dma_irq_gen_bench.sv
module dma_irq_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanStart = 0, wrValid = 0, reqArrive = 0, svcDone = 0, busErr = 0, statusRd = 0;
  logic [7:0] wrPos = '0, frameBytes = 8'd1, frameCount = 8'd1;
  logic [2:0] wrBytes = 3'd1;
  logic [5:0] intEnable = '0;
  logic [5:0] statusData;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;
  int mFrame = 0, mReq = 0;
  logic [5:0] mStatus = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_gen u_dma_irq_gen (
    .clk(clk), .rstN(rstN), .chanStart(chanStart), .wrValid(wrValid),
    .wrPos(wrPos), .wrBytes(wrBytes), .frameBytes(frameBytes),
    .frameCount(frameCount), .reqArrive(reqArrive), .svcDone(svcDone),
    .busErr(busErr), .statusRd(statusRd), .intEnable(intEnable),
    .statusData(statusData), .irq(irq)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] expEvt(bit st, bit wr, int pos, int nb, int fb, int fc,
                                        bit arr, bit dn, bit err);
    int f = st ? 0 : mFrame;
    int q = st ? 0 : mReq;
    bit last = (f == fc - 1);
    bit endHit = wr && (pos < fb) && (pos + nb >= fb);
    bit midHit = wr && (pos <= fb / 2) && (pos + nb > fb / 2);
    logic [5:0] e;
    if (dn && q > 0) q = q - 1;
    e[0] = endHit;
    e[1] = midHit;
    e[2] = wr && pos == 0 && last;
    e[3] = endHit && last;
    e[4] = arr && q == 2;
    e[5] = err;
    return e;
  endfunction

  // One cycle: drive, check current outputs, advance model
  task automatic step(bit st, bit wr, int pos, int nb, int fb, int fc, bit arr, bit dn,
                      bit err, bit rd, logic [5:0] en);
    logic [5:0] e;
    string tags[6] = '{"R1", "R2", "R3", "R4", "R6", "R7"};
    chanStart = st; wrValid = wr; wrPos = 8'(pos); wrBytes = 3'(nb);
    frameBytes = 8'(fb); frameCount = 8'(fc); reqArrive = arr; svcDone = dn;
    busErr = err; statusRd = rd; intEnable = en;
    #1;
    for (int i = 0; i < 6; i++)
      chk(statusData[i] === mStatus[i], tags[i], int'(statusData[i]), int'(mStatus[i]));
    chk(irq === |(mStatus & en), "R10", int'(irq), int'(|(mStatus & en)));
    e = expEvt(st, wr, pos, nb, fb, fc, arr, dn, err);
    mStatus = (rd ? 6'd0 : mStatus) | e;
    if (st) begin mFrame = 0; mReq = 0; end
    if (e[0] && !(mFrame == fc - 1)) mFrame++;
    if (dn && mReq > 0) mReq--;
    if (arr && mReq < 2) mReq++;
    @(negedge clk);
  endtask

  task automatic idle(int fb, int fc, bit rd);
    step(0, 0, 0, 1, fb, fc, 0, 0, 0, rd, 6'd0);
  endtask

  task automatic expectStatus(logic [5:0] exp, string tag);
    chk(statusData === exp, tag, int'(statusData), int'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R11 reset state
    #3;
    chk(statusData === 6'd0, "R11 in reset", int'(statusData), 0);
    chk(irq === 1'b0, "R11 irq in reset", int'(irq), 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(statusData === 6'd0, "R11 after reset", int'(statusData), 0);
    chk(irq === 1'b0, "R11 irq after reset", int'(irq), 0);

    // Odd frame of 7 bytes, two frames, enables off (R1 R2 R3 R4 R8)
    step(1, 0, 0, 1, 7, 2, 0, 0, 0, 0, 6'd0);
    step(0, 1, 0, 2, 7, 2, 0, 0, 0, 0, 6'd0);
    idle(7, 2, 0);
    expectStatus(6'b000000, "R2 mid not yet reached");
    step(0, 1, 2, 2, 7, 2, 0, 0, 0, 0, 6'd0);
    idle(7, 2, 0);
    expectStatus(6'b000010, "R2 mid byte 3 covered");
    step(0, 1, 4, 3, 7, 2, 0, 0, 0, 0, 6'd0);
    idle(7, 2, 0);
    expectStatus(6'b000011, "R1 frame end");
    step(0, 1, 0, 4, 7, 2, 0, 0, 0, 0, 6'd0);
    idle(7, 2, 0);
    expectStatus(6'b000111, "R3 last frame start");
    step(0, 1, 4, 3, 7, 2, 0, 0, 0, 0, 6'd0);
    idle(7, 2, 0);
    expectStatus(6'b001111, "R4 block end, R8 sticky with enables off");
    step(0, 0, 0, 1, 7, 2, 0, 0, 0, 0, 6'b000100);
    chk(irq === 1'b1, "R10 enable raises irq", int'(irq), 1);
    step(0, 0, 0, 1, 7, 2, 0, 0, 0, 0, 6'b010000);
    chk(irq === 1'b0, "R10 masked bit keeps irq low", int'(irq), 0);
    // R9 read returns then clears, same-cycle event survives
    chanStart = 0; wrValid = 0; statusRd = 1; busErr = 1; #1;
    expectStatus(6'b001111, "R9 read returns held bits");
    step(0, 0, 0, 1, 7, 2, 0, 0, 1, 1, 6'd0);
    expectStatus(6'b100000, "R9 clear keeps same-cycle event, R7");
    step(0, 0, 0, 1, 7, 2, 0, 0, 0, 1, 6'd0);
    expectStatus(6'b000000, "R9 second read empties");

    // R6 request drop
    step(0, 0, 0, 1, 7, 2, 1, 0, 0, 0, 6'd0);
    step(0, 0, 0, 1, 7, 2, 1, 0, 0, 0, 6'd0);
    expectStatus(6'b000000, "R6 two outstanding is no drop");
    step(0, 0, 0, 1, 7, 2, 1, 1, 0, 0, 6'd0);
    expectStatus(6'b000000, "R6 done with arrival is no drop");
    step(0, 0, 0, 1, 7, 2, 1, 0, 0, 0, 6'd0);
    expectStatus(6'b010000, "R6 third arrival drops");
    step(0, 0, 0, 1, 7, 2, 0, 0, 0, 1, 6'd0);
    step(1, 0, 0, 1, 7, 2, 1, 0, 0, 0, 6'd0);
    step(0, 0, 0, 1, 7, 2, 1, 0, 0, 0, 6'd0);
    expectStatus(6'b000000, "R6 chanStart empties request count");

    // R5 restart mid-block with same-cycle write judged as frame 0
    step(1, 1, 0, 4, 4, 3, 0, 0, 0, 1, 6'd0);
    step(0, 0, 0, 1, 4, 1, 0, 0, 0, 1, 6'd0);
    step(1, 1, 0, 4, 4, 1, 0, 0, 0, 0, 6'd0);
    expectStatus(6'b001111, "R5 start-cycle write in frame 0");
    // One-byte frame: end and middle coincide
    step(1, 1, 0, 1, 1, 1, 0, 0, 0, 1, 6'd0);
    expectStatus(6'b001111, "R2 one-byte frame mid is byte 0");
    idle(1, 1, 1);

    // Random blocks
    for (int b = 0; b < 30; b++) begin
      int fb = 1 + int'($urandom % 40);
      int fc = 1 + int'($urandom % 4);
      step(1, 0, 0, 1, fb, fc, 0, 0, 0, 0, 6'($urandom));
      for (int f = 0; f < fc; f++) begin
        int pos = 0;
        while (pos < fb) begin
          int nb = 1 << ($urandom % 3);
          bit wr = ($urandom % 4) != 0;
          if (nb > fb - pos) nb = fb - pos;
          step(0, wr, pos, nb, fb, fc, ($urandom % 3) == 0, ($urandom % 3) == 0,
               ($urandom % 16) == 0, ($urandom % 8) == 0, 6'($urandom));
          if (wr) pos += nb;
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule